// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a 32.768 kHz timebase into periodic interrupt events. The timebase arrives as a one-cycle `tick` strobe in the system clock domain. A 16-bit counter counts these ticks freely from reset. A 4-bit rate code and an enable bit come from the control registers. Together they select a power-of-two period, and an event fires on every tick that brings the counter onto a multiple of that period.

Each event sets two sticky status flags, the interrupt-request flag and the periodic flag, and drives the interrupt line, which follows the request flag. Both flags stay set until a one-cycle clear strobe arrives, typically when the status register is read. Rate and enable are decoded combinationally, so a reprogram takes effect on the next tick. The first event after a change lands on the next period multiple of the running count, not one whole period after the write.

Top module: `pirq_rate_gen`

## Requirements
- R1: A synchronous reset sets the tick counter to 0 and clears both status flags and the interrupt output. All three are low in the cycle after reset.
- R2: The tick counter is 16 bits wide. It advances by one on every cycle with `tick` high, holds on every other cycle, and wraps from 65535 to 0. Events are only possible on tick cycles.
- R3: For rate codes 3 through 15, the period is 2^(code-1) ticks. An event fires on the tick that makes the counter value a multiple of the period.
- R4: Rate code 1 gives a period of 128 ticks and rate code 2 gives a period of 256 ticks, the same as codes 8 and 9.
- R5: Rate code 0 produces no events, whatever the enable says.
- R6: With `pie_en` low, no events are produced. The counter keeps running.
- R7: An event sets `flag_irq` and `flag_periodic` and raises `irq` at the same clock edge that advances the counter onto the period multiple.
- R8: Once set, both flags and `irq` hold until `stat_clr` is high for a cycle. That clear drops all three at the next edge.
- R9: When an event and `stat_clr` fall in the same cycle, the event wins and the flags end up set.
- R10: A change to `rate_code` or `pie_en` applies from the next tick. The next event comes on the next multiple of the new period on the running count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe per 32.768 kHz cycle |
| rate_code | input | 4 | Rate-select code from control register A |
| pie_en | input | 1 | Periodic interrupt enable from control register B |
| stat_clr | input | 1 | One-cycle clear of the status flags |
| irq | output | 1 | Interrupt request line |
| flag_irq | output | 1 | Status interrupt-request flag |
| flag_periodic | output | 1 | Status periodic-event flag |

## Verification
The stimulus covers several patterns:
- Short periods with ticks on every cycle and with ticks on every other cycle. These separate counting of ticks from counting of clocks.
- Both folded codes next to a plain code. These separate the folding from straight decoding.
- Code 0 and a dropped enable, each run for several short periods. These show that no event leaks through.
- A clear held high during events, and long runs with no clear. These separate set-priority from sticky hold.
- A switch from a long period to a short one in mid-count, followed by a run past the 16-bit wrap. These show that events follow count multiples rather than the time of the write.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    typedef struct packed {
        logic req;
        logic per;
    } stat_t;

    localparam stat_t STAT_IDLE = '{req: 1'b0, per: 1'b0};
    localparam stat_t STAT_HIT  = '{req: 1'b1, per: 1'b1};

endpackage

// File: rtl/pirq_rate_decode.sv
module pirq_rate_decode #(
    parameter int CODE_W   = 4,
    parameter int CNT_W    = 16,
    parameter int FOLD_MAX = 2,
    parameter int FOLD_ADD = 7
) (
    input  logic [CODE_W-1:0] code,
    input  logic              en,
    output logic              active,
    output logic [CNT_W-1:0]  mask
);
    localparam int EFF_W = CODE_W + 1;

    logic [EFF_W-1:0] eff;
    logic [CNT_W:0]   one_hot;

    always_comb begin
        eff = {1'b0, code};
        if (code != '0 && int'(code) <= FOLD_MAX)
            eff = eff + EFF_W'(FOLD_ADD);
        one_hot = '0;
        if (code != '0)
            one_hot = (CNT_W+1)'(1) << (eff - EFF_W'(1));
        mask   = one_hot[CNT_W-1:0] - CNT_W'(1);
        active = en && (code != '0);
    end

    always_comb begin
        if (code == CODE_W'(1)) assert_fold_one_R4: assert (mask == CNT_W'(127));
        if (code == CODE_W'(2)) assert_fold_two_R4: assert (mask == CNT_W'(255));
    end
endmodule

// File: rtl/pirq_tick_counter.sv
module pirq_tick_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_nxt
);
    always_comb cnt_nxt = tick ? cnt + CNT_W'(1) : cnt;

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt_nxt;
    end

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        tick |=> cnt == $past(cnt) + CNT_W'(1));
    assert_count_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));
endmodule

// File: rtl/pirq_flag_reg.sv
module pirq_flag_reg
    import pirq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  set,
    input  logic  clr,
    output stat_t stat
);
    always_ff @(posedge clk) begin
        if (rst)      stat <= STAT_IDLE;
        else if (set) stat <= STAT_HIT;
        else if (clr) stat <= STAT_IDLE;
    end

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        set |=> stat.req && stat.per);
    assert_clear_drops_R8: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !stat.req && !stat.per);
    assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!clr && !set) |=> $stable(stat));
    assert_flags_paired_R7: assert property (@(posedge clk) disable iff (rst)
        stat.req == stat.per);
endmodule

// File: rtl/pirq_rate_gen.sv
module pirq_rate_gen
    import pirq_pkg::*;
#(
    parameter int CODE_W   = 4,
    parameter int CNT_W    = 16,
    parameter int FOLD_MAX = 2,
    parameter int FOLD_ADD = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [CODE_W-1:0] rate_code,
    input  logic              pie_en,
    input  logic              stat_clr,
    output logic              irq,
    output logic              flag_irq,
    output logic              flag_periodic
);
    logic             active;
    logic [CNT_W-1:0] mask;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;
    logic             evt;
    stat_t            stat;

    pirq_rate_decode #(
        .CODE_W(CODE_W), .CNT_W(CNT_W), .FOLD_MAX(FOLD_MAX), .FOLD_ADD(FOLD_ADD)
    ) u_dec (
        .code(rate_code), .en(pie_en), .active(active), .mask(mask)
    );

    pirq_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .cnt(cnt), .cnt_nxt(cnt_nxt)
    );

    always_comb evt = tick && active && ((cnt_nxt & mask) == '0);

    pirq_flag_reg u_flag (
        .clk(clk), .rst(rst), .set(evt), .clr(stat_clr), .stat(stat)
    );

    assign flag_irq      = stat.req;
    assign flag_periodic = stat.per;
    assign irq           = stat.req;

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> !irq && !flag_periodic && cnt == '0);
    assert_code_zero_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (rate_code == '0) |-> !evt);
    assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !pie_en |-> !evt);
    assert_event_needs_tick_R2: assert property (@(posedge clk) disable iff (rst)
        !tick |-> !evt);
endmodule

// File: tb/sim_pirq_rate_gen.sv
module sim_pirq_rate_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [3:0] rate_code = '0;
    logic       pie_en = 1'b0;
    logic       stat_clr = 1'b0;
    logic       irq, flag_irq, flag_periodic;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    int m_cnt = 0;
    bit m_flag = 1'b0;
    bit   expq[$];
    string tagq[$];

    always #4 clk = ~clk;

    pirq_rate_gen u0 (
        .clk(clk), .rst(rst), .tick(tick), .rate_code(rate_code),
        .pie_en(pie_en), .stat_clr(stat_clr), .irq(irq),
        .flag_irq(flag_irq), .flag_periodic(flag_periodic)
    );

    function automatic int period_of(input logic [3:0] c);
        int e = int'(c);
        if (e == 1 || e == 2) e = e + 7;
        return 1 << (e - 1);
    endfunction

    task automatic step(input bit r, input bit t, input logic [3:0] c,
                        input bit en, input bit cl, input string tag);
        int nxt;
        bit ev;
        @(negedge clk);
        rst = r; tick = t; rate_code = c; pie_en = en; stat_clr = cl;
        if (r) begin
            m_cnt = 0; m_flag = 1'b0;
        end else begin
            nxt = t ? ((m_cnt + 1) % 65536) : m_cnt;
            ev = t && en && (c != 0) && ((nxt % period_of(c)) == 0);
            if (ev) m_flag = 1'b1;
            else if (cl) m_flag = 1'b0;
            m_cnt = nxt;
        end
        expq.push_back(m_flag);
        tagq.push_back(tag);
    endtask

    always @(posedge clk) begin
        #2;
        if (expq.size() > 0) begin
            bit e;
            string tg;
            e = expq.pop_front();
            tg = tagq.pop_front();
            vectors++;
            if (irq !== e || flag_irq !== e || flag_periodic !== e) begin
                miscompares++;
                $display("FAIL %s: irq/req/per=%b%b%b expected %b%b%b",
                         tg, irq, flag_irq, flag_periodic, e, e, e);
            end
        end
    end

    task automatic run(input int n, input int tick_every, input logic [3:0] c,
                       input bit en, input int clr_mode, input string tag);
        for (int i = 0; i < n; i++) begin
            bit cl;
            cl = (clr_mode == 1) ? 1'b1 : (clr_mode == 2) ? m_flag : 1'b0;
            step(1'b0, (i % tick_every) == 0, c, en, cl, tag);
        end
    endtask

    initial begin
        // R1: reset state
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 4'd3, 1'b1, 1'b0, "R1");
        run(1, 1, 4'd0, 1'b0, 0, "R1");
        // R3 R7 R8: period 4 with clear after each event
        run(40, 1, 4'd3, 1'b1, 2, "R3_R7");
        // R2: ticks on every other cycle, period 32
        run(200, 2, 4'd6, 1'b1, 2, "R2");
        // R4: folded codes
        run(400, 1, 4'd1, 1'b1, 2, "R4");
        run(700, 1, 4'd2, 1'b1, 2, "R4");
        // R5: code zero stays quiet
        run(300, 1, 4'd0, 1'b1, 2, "R5");
        // R6: enable low stays quiet
        run(300, 1, 4'd3, 1'b0, 2, "R6");
        // R9: clear held through events
        run(30, 1, 4'd3, 1'b1, 1, "R9");
        // R8: sticky with no clear
        run(60, 1, 4'd4, 1'b1, 0, "R8");
        run(5, 1, 4'd4, 1'b0, 1, "R8");
        // R10: long period, mid-count switch to short one
        run(77, 1, 4'd8, 1'b1, 2, "R10");
        run(20, 1, 4'd3, 1'b1, 2, "R10");
        // R2 R3: slowest rate across the 16-bit wrap
        run(70000, 1, 4'd15, 1'b1, 2, "R2_R3");
        step(1'b0, 1'b0, 4'd0, 1'b0, 1'b0, "R2");
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #1600000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule